// File: doc/BRIEF.md
# Pulse-Coded Isolation Channel with Loss-of-Pulse Watchdog

This block carries one logic level across an isolation barrier without sending the level itself. The transmit side sends one-cycle strobes: a set strobe when its input rises, and a clear strobe when it falls. While the input stays idle it repeats the current level as a refresh strobe at a fixed interval. The receive side holds the level in a set/clear latch. A watchdog on the receive side forces the output to its safe low default when strobes stop arriving.

Each side has its own supply-good flag. A low flag on either side drives the output low. When the transmit supply comes back, the encoder sends the current level at once. When the receive supply or the link comes back, the next refresh restores the output.

The `linkUp` input models the barrier itself: while it is low, both strobes are blocked. Time is measured in clock cycles. The parameter `REFRESH_CYCLES` sets the refresh period. The parameter `WATCHDOG_CYCLES` sets the loss-of-pulse timeout and must be larger than the refresh period.

Top module: `iso_pulse_channel`

## Requirements
- R1: During reset, and after reset until the first strobe is latched, `dataOut` is low.
- R2: With both supplies good and the link up, the level on `dataIn` at clock edge n appears on `dataOut` after edge n+1. This holds once the channel has been healthy for a refresh period.
- R3: An input high for a single clock cycle is reproduced as a single-cycle high on `dataOut`, two edges later.
- R4: The encoder sends a refresh strobe carrying the current level after exactly `REFRESH_CYCLES` edges without a strobe. An idle input therefore keeps `dataOut` at its level indefinitely. An input transition that falls on the cycle a refresh is due is still sent with its new level.
- R5: When the link drops, `dataOut` goes low no later than `WATCHDOG_CYCLES` edges after the cut. It still shows a high level `WATCHDOG_CYCLES - REFRESH_CYCLES` edges after the cut.
- R6: With the link up, `dataOut` is low from the second edge after `txSupplyOk` falls and stays low while it is low, whatever `dataIn` does.
- R7: `dataOut` is low in the same cycle that `rxSupplyOk` is low.
- R8: Two edges after `txSupplyOk` rises (receive side good, link up), `dataOut` equals `dataIn`. It is still low one edge after the rise.
- R9: After `rxSupplyOk` or `linkUp` returns high, `dataOut` equals `dataIn` within `REFRESH_CYCLES` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 1 | Logic level to be carried across the barrier |
| txSupplyOk | input | 1 | Transmit-side supply good (high = above lockout) |
| rxSupplyOk | input | 1 | Receive-side supply good (high = above lockout) |
| linkUp | input | 1 | Barrier intact; low blocks both strobes |
| dataOut | output | 1 | Recovered level on the receive side |

## Verification
The encoder can find a refresh due in the same cycle as an input transition. The bench provokes this by toggling the input at exactly the refresh period, so each new edge lands on the cycle a refresh would fire. The result is judged by comparing the output, cycle by cycle, with the input delayed by two edges. A refresh that carried the stale level, or a transition lost to the refresh, shows up as a one-cycle mismatch.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

  // Strobes crossing the barrier: one-cycle pulses, at most one high.
  typedef struct packed {
    logic setPulse;
    logic clrPulse;
  } iso_strobe_t;

  localparam iso_strobe_t STROBE_NONE = '{setPulse: 1'b0, clrPulse: 1'b0};

  function automatic iso_strobe_t levelStrobe(input logic level);
    iso_strobe_t s;
    s.setPulse = level;
    s.clrPulse = ~level;
    return s;
  endfunction

endpackage

// File: rtl/iso_edge_encoder.sv
module iso_edge_encoder
  import iso_link_pkg::*;
#(
  parameter int REFRESH_CYCLES = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dataIn,
  input  logic        supplyOk,
  output iso_strobe_t strobeOut
);
  localparam int CW = $clog2(REFRESH_CYCLES + 1);
  localparam logic [CW-1:0] REFRESH_LAST = CW'(REFRESH_CYCLES - 1);

  logic          supplyOkQ;
  logic          levelQ;
  logic [CW-1:0] idleCnt;
  iso_strobe_t   strobeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supplyOkQ <= 1'b0;
      levelQ    <= 1'b0;
      idleCnt   <= '0;
      strobeQ   <= STROBE_NONE;
    end else begin
      supplyOkQ <= supplyOk;
      if (!supplyOk) begin
        // Going down: one clear strobe on the falling supply, then silence.
        strobeQ <= supplyOkQ ? levelStrobe(1'b0) : STROBE_NONE;
        levelQ  <= 1'b0;
        idleCnt <= '0;
      end else if (!supplyOkQ || (dataIn != levelQ)) begin
        // Power-up or transition: send the present level at once (wins over refresh).
        strobeQ <= levelStrobe(dataIn);
        levelQ  <= dataIn;
        idleCnt <= '0;
      end else if (idleCnt == REFRESH_LAST) begin
        strobeQ <= levelStrobe(levelQ);
        idleCnt <= '0;
      end else begin
        strobeQ <= STROBE_NONE;
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  assign strobeOut = strobeQ;

  // R8: first good-supply cycle sends the sampled level.
  a_r8_powerup_level: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !supplyOkQ) |=>
      (strobeOut.setPulse == $past(dataIn)) && (strobeOut.clrPulse == !$past(dataIn)));

  // R4: an idle interval that has run out always yields a strobe.
  a_r4_refresh_due: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && supplyOkQ && (dataIn == levelQ) && (idleCnt == REFRESH_LAST)) |=>
      (strobeOut.setPulse || strobeOut.clrPulse));

  // R4: strobes never collide.
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobeOut.setPulse, strobeOut.clrPulse}));

endmodule

// File: rtl/iso_latch_decoder.sv
module iso_latch_decoder
  import iso_link_pkg::*;
#(
  parameter int WATCHDOG_CYCLES = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  iso_strobe_t strobeIn,
  input  logic        supplyOk,
  output logic        dataOut
);
  localparam int WW = $clog2(WATCHDOG_CYCLES + 1);
  localparam logic [WW-1:0] WD_LAST = WW'(WATCHDOG_CYCLES - 1);

  logic          latchQ;
  logic          expiredQ;
  logic [WW-1:0] gapCnt;
  logic          anyPulse;

  assign anyPulse = strobeIn.setPulse | strobeIn.clrPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= 1'b0;
      expiredQ <= 1'b1;   // no pulse seen yet counts as expired
      gapCnt   <= '0;
    end else if (!supplyOk) begin
      latchQ   <= 1'b0;
      expiredQ <= 1'b1;
      gapCnt   <= '0;
    end else if (anyPulse) begin
      latchQ   <= ~strobeIn.clrPulse;  // clear wins a tie
      expiredQ <= 1'b0;
      gapCnt   <= '0;
    end else if (!expiredQ) begin
      if (gapCnt == WD_LAST) expiredQ <= 1'b1;
      else                   gapCnt   <= gapCnt + 1'b1;
    end
  end

  assign dataOut = latchQ & ~expiredQ & supplyOk;

  // R2: a set strobe on a powered receiver drives the output high.
  a_r2_set_follows: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && strobeIn.setPulse && !strobeIn.clrPulse) |=> (dataOut || !supplyOk));

  // R2: a clear strobe always drives the output low.
  a_r2_clr_follows: assert property (@(posedge clk) disable iff (!rstN)
    strobeIn.clrPulse |=> !dataOut);

  // R5: the last silent cycle of the timeout forces the output low.
  a_r5_watchdog_trip: assert property (@(posedge clk) disable iff (!rstN)
    (supplyOk && !anyPulse && !expiredQ && (gapCnt == WD_LAST)) |=> !dataOut);

endmodule

// File: rtl/iso_pulse_channel.sv
module iso_pulse_channel
  import iso_link_pkg::*;
#(
  parameter int REFRESH_CYCLES  = 50,
  parameter int WATCHDOG_CYCLES = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic dataIn,
  input  logic txSupplyOk,
  input  logic rxSupplyOk,
  input  logic linkUp,
  output logic dataOut
);
  iso_strobe_t txStrobe;
  iso_strobe_t rxStrobe;

  generate
    if (WATCHDOG_CYCLES <= REFRESH_CYCLES) begin : g_bad_timing
      initial $error("watchdog timeout must exceed refresh interval");
    end
  endgenerate

  iso_edge_encoder #(.REFRESH_CYCLES(REFRESH_CYCLES)) uEnc (
    .clk(clk), .rstN(rstN), .dataIn(dataIn),
    .supplyOk(txSupplyOk), .strobeOut(txStrobe)
  );

  // The barrier: strobes pass only while the link is intact.
  assign rxStrobe = linkUp ? txStrobe : STROBE_NONE;

  iso_latch_decoder #(.WATCHDOG_CYCLES(WATCHDOG_CYCLES)) uDec (
    .clk(clk), .rstN(rstN), .strobeIn(rxStrobe),
    .supplyOk(rxSupplyOk), .dataOut(dataOut)
  );

  // R7: receive lockout keeps the output low.
  a_r7_rx_lockout: assert property (@(posedge clk) disable iff (!rstN)
    !rxSupplyOk |-> !dataOut);

  // R6: second edge after a transmit supply fall, with link up, shows low.
  a_r6_tx_lockout: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txSupplyOk, 3) && !$past(txSupplyOk, 2) && !$past(txSupplyOk) && $past(linkUp))
      |-> !dataOut);

endmodule

// File: tb/sim_iso_pulse_channel.sv
module sim_iso_pulse_channel;
  localparam int R  = 50;
  localparam int WD = 250;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b1;
  logic txOk = 1'b0;
  logic rxOk = 1'b1;
  logic linkUp = 1'b1;
  logic dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R2";

  logic prevIn1 = 1'b0, prevIn2 = 1'b0;
  int goodCnt = 0, txLowCnt = 0, linkDownCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  iso_pulse_channel #(.REFRESH_CYCLES(R), .WATCHDOG_CYCLES(WD)) u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .txSupplyOk(txOk),
    .rxSupplyOk(rxOk), .linkUp(linkUp), .dataOut(dataOut)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference state: input history and health counters.
  always @(posedge clk) begin
    prevIn2     <= prevIn1;
    prevIn1     <= dataIn;
    goodCnt     <= (rstN && txOk && rxOk && linkUp) ? goodCnt + 1 : 0;
    txLowCnt    <= (rstN && !txOk) ? txLowCnt + 1 : 0;
    linkDownCnt <= (rstN && !linkUp) ? linkDownCnt + 1 : 0;
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN)                                  chk("R1", dataOut, 1'b0);
      else if (!rxOk)                             chk("R7", dataOut, 1'b0);
      else if (txLowCnt >= 2 && linkUp)           chk("R6", dataOut, 1'b0);
      else if (linkDownCnt >= WD && txOk)         chk("R5", dataOut, 1'b0);
      else if (goodCnt >= R + 2)                  chk(tag, dataOut, prevIn2);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    // R1: reset, then release with the transmit side still down.
    step(4);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R1", dataOut, 1'b0);
    end
    // R8: transmit power-up with input high.
    step(1);
    txOk = 1'b1;
    @(negedge clk);                 // before the next edge
    @(negedge clk); chk("R8", dataOut, 1'b0);
    @(negedge clk); chk("R8", dataOut, 1'b1);

    // R2: irregular input pattern.
    step(R + 5);
    tag = "R2";
    for (int i = 0; i < 200; i++) begin
      dataIn = ~dataIn;
      step($urandom_range(1, 8));
    end

    // R3: single-cycle pulses.
    tag = "R3";
    for (int i = 0; i < 4; i++) begin
      dataIn = 1'b0;
      step(6);
      dataIn = 1'b1;
      step(1);
      dataIn = 1'b0;
      @(posedge clk);
      @(negedge clk); chk("R3", dataOut, 1'b1);
      @(negedge clk); chk("R3", dataOut, 1'b0);
      step(1);
    end

    // R4: long idle high, then edges landing on the refresh-due cycle.
    tag = "R4";
    dataIn = 1'b1;
    step(5 * WD);
    @(negedge clk); chk("R4", dataOut, 1'b1);
    step(1);
    for (int i = 0; i < 10; i++) begin
      dataIn = ~dataIn;
      step(R);
    end
    dataIn = 1'b0;
    step(3 * WD);

    // R5: cut the link with a steady high input.
    tag = "R2";
    dataIn = 1'b1;
    step(R + 5);
    linkUp = 1'b0;
    for (int k = 0; k <= WD; k++) begin
      @(negedge clk);
      if (k == WD - R) chk("R5", dataOut, 1'b1);
      if (k == WD)     chk("R5", dataOut, 1'b0);
    end
    // R9: link restored.
    step(1);
    linkUp = 1'b1;
    repeat (R) @(posedge clk);
    @(negedge clk); chk("R9", dataOut, 1'b1);
    step(R + 5);

    // R7: receive lockout, then R9 recovery.
    rxOk = 1'b0;
    @(negedge clk); chk("R7", dataOut, 1'b0);
    step(1);
    for (int i = 0; i < 6; i++) begin
      dataIn = ~dataIn;
      step(3);
    end
    dataIn = 1'b1;
    step(10);
    rxOk = 1'b1;
    repeat (R) @(posedge clk);
    @(negedge clk); chk("R9", dataOut, 1'b1);
    step(R + 5);

    // R6: transmit lockout while the input keeps moving.
    txOk = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R6", dataOut, 1'b0);
    step(1);
    for (int i = 0; i < 20; i++) begin
      dataIn = ~dataIn;
      step(25);
    end
    dataIn = 1'b1;
    step(3);
    // R8: transmit restore.
    txOk = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R8", dataOut, 1'b0);
    @(negedge clk); chk("R8", dataOut, 1'b1);
    step(R + 10);

    finishRun();
  end
endmodule